// File: doc/BRIEF.md
# Frequency-Compensated Precision Time Counter

This block keeps network time as a 64-bit count of nanoseconds. The reference clock need not be an exact multiple of the nanosecond rate. A 32-bit fractional addend is summed into an accumulator on every reference cycle. Each carry out of that accumulator advances the time count by a programmable tick period. Software trims the clock rate by rewriting the addend while the timer runs. The accumulator keeps its remainder through the change.

A one-shot 64-bit alarm compares the running time against a programmed instant. The alarm can release a periodic pulse generator, so that software can align the pulse train with whole seconds. To do this it sets the alarm one tick before the boundary and programs the pulse period minus one tick. All configuration goes through a small word-addressed register bus with a one-cycle read latency. The 64-bit quantities are split into low and high words. The high-word access is the one that takes effect.

Top module: `ptc_timer`

## Requirements
- R1: After a synchronous reset, every register reads back as zero, and alarm_evt, pulse_evt and pulse_out are low.
- R2: A read of the count low word (address 2) returns the low 32 bits and freezes the matching high 32 bits. A later read of the count high word (address 3) returns that frozen half, even if the count has since carried across a word boundary.
- R3: A write to address 2 only stages the low word; the count does not change. A write to address 3 loads the 64-bit value {written high word, staged low word} into the count at that edge.
- R4: While enabled, the addend (address 1) is summed into a 32-bit accumulator every reference cycle. On each carry out of bit 31 the count grows by the tick field, which is control bits 15:8 at address 0.
- R5: A new addend takes effect on the next reference cycle and leaves the accumulator remainder intact.
- R6: While the enable bit (control bit 0) is clear, neither the count nor the accumulator moves.
- R7: Writing the alarm high word (address 5, after the low word at address 4) arms the alarm. The first cycle in which the timer is enabled, the alarm is armed and the count is at or above the alarm value raises alarm_evt for one cycle on the next edge, and the alarm then disarms.
- R8: With the start-on-alarm bit (control bit 1) set, the pulse generator stays idle until the alarm hits. It fires at the first tick after the hit, then once per period value + tick nanoseconds, with the period written at address 6.
- R9: Each pulse raises pulse_evt for one cycle, and pulse_out goes high for PULSE_CYC (default 4) reference cycles, starting in the same cycle.
- R10: When a count high-word write and an accumulator carry land on the same edge, the written value is loaded and that tick is dropped. The accumulator still advances.
- R11: The control word reads back exactly as written, including the clock-select field in bits 19:16. That field is stored and has no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_re |
| alarm_evt | output | 1 | One-cycle alarm hit strobe |
| pulse_evt | output | 1 | One-cycle periodic pulse strobe |
| pulse_out | output | 1 | Stretched periodic pulse |

## Verification
Two events can land on the same edge: a software load of the count and a hardware tick from an accumulator carry. The bench turns the timer on with an addend of half the range, so carries fall on every second edge from a known phase. It then places the high-word write exactly on a carry edge. A later read must equal the loaded value plus only the ticks after the load. An extra tick shows that the increment won the race. The start of the pulse generator and its first tick are also timed to the edge against the alarm hit.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    RA_CTRL   = 3'd0,
    RA_ADDEND = 3'd1,
    RA_CNT_LO = 3'd2,
    RA_CNT_HI = 3'd3,
    RA_ALM_LO = 3'd4,
    RA_ALM_HI = 3'd5,
    RA_PERIOD = 3'd6
  } reg_addr_e;

  localparam int CTRL_EN_BIT    = 0;
  localparam int CTRL_SOA_BIT   = 1;
  localparam int CTRL_TICK_LSB  = 8;
  localparam int CTRL_CKSEL_LSB = 16;
endpackage

// File: rtl/ptc_accum.sv
module ptc_accum #(
  parameter int ACC_W  = 32,
  parameter int CNT_W  = 64,
  parameter int TICK_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [ACC_W-1:0]  addend,
  input  logic [TICK_W-1:0] tick,
  input  logic              load,
  input  logic [CNT_W-1:0]  load_val,
  output logic [CNT_W-1:0]  count,
  output logic              step
);
  logic [ACC_W:0]   sum;
  logic [ACC_W-1:0] acc_q;

  assign sum  = {1'b0, acc_q} + {1'b0, addend};
  assign step = enable & sum[ACC_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      count <= '0;
    end else begin
      if (enable) acc_q <= sum[ACC_W-1:0];
      if (load)      count <= load_val;
      else if (step) count <= count + CNT_W'(tick);
    end
  end

  AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (!enable && !load) |=> $stable(count)); // R6
  AST_ACC_IDLE: assert property (@(posedge clk) disable iff (rst)
    !enable |=> $stable(acc_q)); // R6
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    load |=> (count == $past(load_val))); // R10
  AST_STEP_SIZE: assert property (@(posedge clk) disable iff (rst)
    (enable && !load) |=> (count == $past(count) ||
                           count == $past(count) + CNT_W'($past(tick)))); // R4
endmodule

// File: rtl/ptc_alarm.sv
module ptc_alarm #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             arm,
  input  logic [CNT_W-1:0] arm_val,
  input  logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] alarm_val,
  output logic             hit,
  output logic             alarm_evt
);
  logic armed_q;

  assign hit = armed_q & enable & (count >= alarm_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q   <= 1'b0;
      alarm_val <= '0;
      alarm_evt <= 1'b0;
    end else begin
      alarm_evt <= hit;
      if (arm) begin
        armed_q   <= 1'b1;
        alarm_val <= arm_val;
      end else if (hit) begin
        armed_q <= 1'b0;
      end
    end
  end

  AST_ALARM_ONESHOT: assert property (@(posedge clk) disable iff (rst)
    (hit && !arm) |=> !armed_q); // R7
endmodule

// File: rtl/ptc_pulse.sv
module ptc_pulse #(
  parameter int W         = 32,
  parameter int TICK_W    = 8,
  parameter int PULSE_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              gate,
  input  logic              start,
  input  logic              step,
  input  logic [TICK_W-1:0] tick,
  input  logic [W-1:0]      period,
  output logic              pulse_evt,
  output logic              pulse_out
);
  localparam int HC_W = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;

  logic            running;
  logic [W-1:0]    rem;
  logic [HC_W-1:0] hold;
  logic            fire;

  assign fire = enable & running & step & (rem < W'(tick));

  always_ff @(posedge clk) begin
    if (rst) begin
      running   <= 1'b0;
      rem       <= '0;
      pulse_evt <= 1'b0;
      pulse_out <= 1'b0;
      hold      <= '0;
    end else begin
      pulse_evt <= fire;
      if (!enable) begin
        running <= 1'b0;
        rem     <= '0;
      end else if (!running) begin
        if (!gate || start) begin
          running <= 1'b1;
          rem     <= '0;
        end
      end else if (step) begin
        if (fire) rem <= period;
        else      rem <= rem - W'(tick);
      end
      if (fire) begin
        pulse_out <= 1'b1;
        hold      <= HC_W'(PULSE_CYC - 1);
      end else if (hold != '0) begin
        hold <= hold - 1'b1;
      end else begin
        pulse_out <= 1'b0;
      end
    end
  end

  AST_PULSE_WITH_EVT: assert property (@(posedge clk) disable iff (rst)
    pulse_evt |-> pulse_out); // R9
  AST_NO_PULSE_IDLE: assert property (@(posedge clk) disable iff (rst)
    pulse_evt |-> $past(running)); // R8
endmodule

// File: rtl/ptc_timer.sv
module ptc_timer
  import ptc_pkg::*;
#(
  parameter int TICK_W    = 8,
  parameter int CKSEL_W   = 4,
  parameter int PULSE_CYC = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_we,
  input  logic        bus_re,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        alarm_evt,
  output logic        pulse_evt,
  output logic        pulse_out
);
  localparam int CNT_W = 2 * WORD_W;

  logic               en_q, soa_q;
  logic [TICK_W-1:0]  tick_q;
  logic [CKSEL_W-1:0] cksel_q;
  logic [WORD_W-1:0]  addend_q, cnt_lo_sh, alm_lo_sh, period_q, hi_snap;
  logic [WORD_W-1:0]  ctrl_rd;
  logic [CNT_W-1:0]   count, alarm_val;
  logic               step, hit, cnt_load, alm_arm;
  reg_addr_e          ra;

  assign ra       = reg_addr_e'(bus_addr);
  assign cnt_load = bus_we && (ra == RA_CNT_HI);
  assign alm_arm  = bus_we && (ra == RA_ALM_HI);

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[CTRL_EN_BIT]  = en_q;
    ctrl_rd[CTRL_SOA_BIT] = soa_q;
    ctrl_rd[CTRL_TICK_LSB +: TICK_W]   = tick_q;
    ctrl_rd[CTRL_CKSEL_LSB +: CKSEL_W] = cksel_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0; soa_q <= 1'b0; tick_q <= '0; cksel_q <= '0;
      addend_q <= '0; cnt_lo_sh <= '0; alm_lo_sh <= '0; period_q <= '0;
    end else if (bus_we) begin
      case (ra)
        RA_CTRL: begin
          en_q    <= bus_wdata[CTRL_EN_BIT];
          soa_q   <= bus_wdata[CTRL_SOA_BIT];
          tick_q  <= bus_wdata[CTRL_TICK_LSB +: TICK_W];
          cksel_q <= bus_wdata[CTRL_CKSEL_LSB +: CKSEL_W];
        end
        RA_ADDEND: addend_q  <= bus_wdata;
        RA_CNT_LO: cnt_lo_sh <= bus_wdata;
        RA_ALM_LO: alm_lo_sh <= bus_wdata;
        RA_PERIOD: period_q  <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      hi_snap   <= '0;
    end else if (bus_re) begin
      case (ra)
        RA_CTRL:   bus_rdata <= ctrl_rd;
        RA_ADDEND: bus_rdata <= addend_q;
        RA_CNT_LO: begin
          bus_rdata <= count[WORD_W-1:0];
          hi_snap   <= count[CNT_W-1:WORD_W];
        end
        RA_CNT_HI: bus_rdata <= hi_snap;
        RA_ALM_LO: bus_rdata <= alarm_val[WORD_W-1:0];
        RA_ALM_HI: bus_rdata <= alarm_val[CNT_W-1:WORD_W];
        RA_PERIOD: bus_rdata <= period_q;
        default:   bus_rdata <= '0;
      endcase
    end
  end

  ptc_accum #(.ACC_W(WORD_W), .CNT_W(CNT_W), .TICK_W(TICK_W)) u_accum (
    .clk(clk), .rst(rst), .enable(en_q), .addend(addend_q), .tick(tick_q),
    .load(cnt_load), .load_val({bus_wdata, cnt_lo_sh}),
    .count(count), .step(step)
  );

  ptc_alarm #(.CNT_W(CNT_W)) u_alarm (
    .clk(clk), .rst(rst), .enable(en_q), .arm(alm_arm),
    .arm_val({bus_wdata, alm_lo_sh}), .count(count),
    .alarm_val(alarm_val), .hit(hit), .alarm_evt(alarm_evt)
  );

  ptc_pulse #(.W(WORD_W), .TICK_W(TICK_W), .PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk(clk), .rst(rst), .enable(en_q), .gate(soa_q), .start(hit),
    .step(step), .tick(tick_q), .period(period_q),
    .pulse_evt(pulse_evt), .pulse_out(pulse_out)
  );

  AST_SNAP_STABLE: assert property (@(posedge clk) disable iff (rst)
    !(bus_re && ra == RA_CNT_LO) |=> $stable(hi_snap)); // R2
endmodule

// File: tb/test_ptc_timer.sv
module test_ptc_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        alarm_evt, pulse_evt, pulse_out;

  int n_cmp = 0, n_bad = 0;
  int edge_n = 0;
  bit done = 1'b0;

  int alm_cnt, alm_edge, pls_cnt, pls_edge1, pls_edge2, pout_cnt;

  ptc_timer i_ptc_timer (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .alarm_evt(alarm_evt), .pulse_evt(pulse_evt), .pulse_out(pulse_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) edge_n <= edge_n + 1;

  always @(negedge clk) begin
    if (alarm_evt) begin alm_cnt++; alm_edge = edge_n; end
    if (pulse_evt) begin
      pls_cnt++;
      if (pls_cnt == 1) pls_edge1 = edge_n;
      if (pls_cnt == 2) pls_edge2 = edge_n;
    end
    if (pulse_out) pout_cnt++;
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, output int e);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d; e = edge_n + 1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d, output int e);
    bus_re = 1'b1; bus_addr = a; e = edge_n + 1;
    @(negedge clk);
    d = bus_rdata; bus_re = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    alm_cnt = 0; alm_edge = 0; pls_cnt = 0; pls_edge1 = 0; pls_edge2 = 0; pout_cnt = 0;
  endtask

  function automatic logic [63:0] expv(logic [63:0] base, int t, int e, int e0);
    return base + 64'(t) * 64'((e - 1 - e0) / 2);
  endfunction

  task automatic t_reset();
    logic [31:0] d; int e;
    do_reset();
    check("R1 outputs", {61'd0, alarm_evt, pulse_evt, pulse_out}, 64'd0);
    rd(3'd0, d, e); check("R1 ctrl", d, 0);
    rd(3'd1, d, e); check("R1 addend", d, 0);
    rd(3'd2, d, e); check("R1 count lo", d, 0);
    rd(3'd3, d, e); check("R1 count hi", d, 0);
  endtask

  task automatic t_ctrl();
    logic [31:0] d; int e;
    do_reset();
    wr(3'd0, 32'h000A_1000, e);
    wr(3'd1, 32'h1234_5678, e);
    rd(3'd0, d, e); check("R11 ctrl readback", d, 32'h000A_1000);
    rd(3'd1, d, e); check("R11 addend readback", d, 32'h1234_5678);
  endtask

  task automatic t_hold();
    logic [31:0] d; int e;
    do_reset();
    wr(3'd1, 32'h8000_0000, e);
    wr(3'd0, 32'h0000_0800, e);
    wr(3'd2, 32'h0000_1234, e);
    rd(3'd2, d, e); check("R3 low write alone", d, 0);
    wr(3'd3, 32'h0000_0005, e);
    rd(3'd2, d, e); check("R3 loaded lo", d, 32'h1234);
    rd(3'd3, d, e); check("R3 loaded hi", d, 32'h5);
    repeat (20) @(negedge clk);
    rd(3'd2, d, e); check("R6 no advance when disabled", d, 32'h1234);
  endtask

  task automatic t_coherent();
    logic [31:0] d; int e, e0, e1, e3;
    logic [63:0] base = 64'h0000_0000_FFFF_FF00;
    do_reset();
    wr(3'd1, 32'h8000_0000, e);
    wr(3'd2, base[31:0], e);
    wr(3'd3, base[63:32], e);
    wr(3'd0, 32'h0000_1001, e0);
    rd(3'd2, d, e1); check("R4 lo first read", d, expv(base, 16, e1, e0) & 64'hFFFF_FFFF);
    repeat (40) @(negedge clk);
    rd(3'd3, d, e); check("R2 frozen hi", d, expv(base, 16, e1, e0) >> 32);
    rd(3'd2, d, e3); check("R4 lo after rollover", d, expv(base, 16, e3, e0) & 64'hFFFF_FFFF);
    rd(3'd3, d, e); check("R2 hi after rollover", d, expv(base, 16, e3, e0) >> 32);
  endtask

  task automatic t_remainder();
    logic [31:0] d; int e;
    do_reset();
    wr(3'd1, 32'h6000_0000, e);
    wr(3'd0, 32'h0000_0801, e);
    wr(3'd0, 32'h0000_0800, e);
    rd(3'd2, d, e); check("R5 no carry yet", d, 0);
    wr(3'd1, 32'hA000_0000, e);
    wr(3'd0, 32'h0000_0801, e);
    wr(3'd0, 32'h0000_0800, e);
    rd(3'd2, d, e); check("R5 remainder kept", d, 8);
  endtask

  task automatic t_collide();
    logic [31:0] d; int e, e0, er;
    do_reset();
    wr(3'd1, 32'h8000_0000, e);
    wr(3'd0, 32'h0000_0801, e0);
    wr(3'd2, 32'h0000_0500, e);
    wr(3'd3, 32'h0, e);
    repeat (10) @(negedge clk);
    rd(3'd2, d, er);
    check("R10 load beats tick", d, 32'h500 + 8 * ((er - 1 - e0) / 2 - 1));
  endtask

  task automatic t_alarm_pulse();
    int e, e0;
    do_reset();
    wr(3'd1, 32'h8000_0000, e);
    wr(3'd0, 32'h0000_0802, e);
    wr(3'd2, 32'd1000, e);
    wr(3'd3, 32'd0, e);
    wr(3'd6, 32'd72, e);
    wr(3'd4, 32'd1040, e);
    wr(3'd5, 32'd0, e);
    check("R8 idle before enable", pls_cnt, 0);
    wr(3'd0, 32'h0000_0803, e0);
    while (edge_n < e0 + 40) @(negedge clk);
    check("R7 alarm count", alm_cnt, 1);
    check("R7 alarm edge", alm_edge, e0 + 11);
    check("R8 pulse count", pls_cnt, 2);
    check("R8 first pulse edge", pls_edge1, e0 + 12);
    check("R8 second pulse edge", pls_edge2, e0 + 32);
    check("R9 pulse_out width", pout_cnt, 8);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_hold();
    t_coherent();
    t_remainder();
    t_collide();
    t_alarm_pulse();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule